// File: doc/BRIEF.md
# Pulse-Width Single-Wire Frame Receiver

This block listens to one open-drain data line that idles high. Each bit on the line is a low pulse followed by a high pulse. The block times both phases in clock cycles and takes the bit as a one when the high phase lasted longer than the low phase. Bits arrive most significant first and are packed into bytes. Each finished byte appears on a byte output for one cycle, marked by a valid strobe.

A frame starts with a one-cycle pulse on `rxEnable`. The block then waits a long time for the first falling edge. A high phase that runs past the bit timeout closes the frame normally. At that point the block raises a one-cycle done pulse and presents a status value. The status holds one of four things:
- the number of whole bytes received;
- zero, when the line never fell;
- 0xFF, when the line stayed low too long;
- 0xFE, when more bytes arrived than the caller allowed.

The raw line passes through a synchroniser inside the block before any timing is done.

Top module: `pwRx`

## Requirements
- R1: A bit is 1 when its high phase lasts strictly more cycles than its low phase; when the high phase is shorter or equal, the bit is 0.
- R2: Bits are packed most significant bit first. After every eighth bit the byte appears on `rxByte` with `rxValid` high for exactly one cycle. `rxValid` rises on the third clock edge after the pin's falling edge that ends the eighth bit: two synchroniser stages, then the decision register. `rxValid` and `rxDone` are never high together.
- R3: A high phase longer than `BIT_TIMEOUT` cycles ends the frame. `rxDone` pulses for one cycle on the clock edge that comes `BIT_TIMEOUT`+3 edges after the pin's rising edge. `rxStatus` then holds the number of whole bytes emitted.
- R4: Bits of an unfinished byte that are pending when the frame ends normally are dropped: no `rxValid` is given for them and they are not counted in `rxStatus`.
- R5: A low phase longer than `BIT_TIMEOUT` cycles ends the frame with `rxStatus` = 0xFF. A low phase of exactly `BIT_TIMEOUT` cycles is a valid phase.
- R6: If a byte completes while the number of bytes already emitted equals `maxBytes`, the frame ends with `rxStatus` = 0xFE and that byte is not emitted. A `maxBytes` of 0 rejects the first byte. `maxBytes` must stay below 0xFE.
- R7: If the line does not fall within `START_TIMEOUT` cycles after `rxEnable`, the frame ends with `rxStatus` = 0 and no byte is emitted.
- R8: An `rxEnable` pulse while a frame is in progress is ignored; the frame's bytes and final status are unchanged.
- R9: After reset `rxValid` and `rxDone` are low and `rxStatus` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 1 | Raw data line, idle high |
| rxEnable | input | 1 | One-cycle pulse that arms reception of one frame |
| maxBytes | input | 8 | Largest number of bytes accepted in a frame |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe qualifying `rxByte` |
| rxDone | output | 1 | One-cycle pulse at end of frame |
| rxStatus | output | 8 | Byte count, 0xFF line-stuck error, or 0xFE overflow; held until the next frame ends |

## Verification
The bench drives the line on falling clock edges and reads outputs on falling edges. Counted that way, `rxValid` must appear at the third falling edge after the line falls, and must still be low at the second. `rxDone` after a normal end must appear at the falling edge `BIT_TIMEOUT`+3 after the line rises, and must still be low one edge earlier. Both edges are checked directly.

Frame-level results have no fixed latency. For these, the bench counts the strobes captured by a falling-edge monitor and waits, bounded, for the done pulse. It then compares the collected bytes and the status against values computed from the stimulus table.

// File: rtl/pwRxPkg.sv
package pwRxPkg;

  localparam logic [7:0] STAT_STUCK    = 8'hFF;
  localparam logic [7:0] STAT_OVERFLOW = 8'hFE;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOW,
    ST_HIGH
  } rxState_t;

  // strobes issued by control, acted on by the datapath
  typedef struct packed {
    logic clrFrame;
    logic clrStart;
    logic incStart;
    logic loadLow;
    logic incLow;
    logic loadHigh;
    logic incHigh;
    logic takeBit;
    logic endCount;
    logic endStuck;
    logic endOverflow;
  } rxStrobes_t;

endpackage

// File: rtl/pwRxSync.sv
module pwRxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwRxControl.sv
module pwRxControl
  import pwRxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       lineS,
  input  logic       startExpired,
  input  logic       lowExpired,
  input  logic       highExpired,
  input  logic       byteDone,
  input  logic       atMax,
  output rxStrobes_t stb
);
  rxState_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (rxEnable) begin
          stb.clrFrame = 1'b1;
          stb.clrStart = 1'b1;
          stateNext    = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!lineS) begin
          stb.loadLow = 1'b1;
          stateNext   = ST_LOW;
        end else if (startExpired) begin
          stb.endCount = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stb.incStart = 1'b1;
        end
      end
      ST_LOW: begin
        if (lineS) begin
          stb.loadHigh = 1'b1;
          stateNext    = ST_HIGH;
        end else if (lowExpired) begin
          stb.endStuck = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stb.incLow = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!lineS) begin
          if (byteDone && atMax) begin
            stb.endOverflow = 1'b1;
            stateNext       = ST_IDLE;
          end else begin
            stb.takeBit = 1'b1;
            stb.loadLow = 1'b1;
            stateNext   = ST_LOW;
          end
        end else if (highExpired) begin
          stb.endCount = 1'b1;
          stateNext    = ST_IDLE;
        end else begin
          stb.incHigh = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8
  enable_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && rxEnable) |-> !stb.clrFrame);

  // R3
  one_end_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.endCount, stb.endStuck, stb.endOverflow}) <= 1);
endmodule

// File: rtl/pwRxDatapath.sv
module pwRxDatapath
  import pwRxPkg::*;
#(
  parameter int BIT_TIMEOUT   = 5000,
  parameter int START_TIMEOUT = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  rxStrobes_t stb,
  input  logic [7:0] maxBytes,
  output logic       startExpired,
  output logic       lowExpired,
  output logic       highExpired,
  output logic       byteDone,
  output logic       atMax,
  output logic [7:0] rxByte,
  output logic       rxValid,
  output logic       rxDone,
  output logic [7:0] rxStatus
);
  localparam int BIT_W   = $clog2(BIT_TIMEOUT + 1);
  localparam int START_W = $clog2(START_TIMEOUT + 1);
  localparam logic [BIT_W-1:0]   BIT_LIM   = BIT_W'(BIT_TIMEOUT);
  localparam logic [START_W-1:0] START_LIM = START_W'(START_TIMEOUT);

  logic [BIT_W-1:0]   lowCnt, lowLen, highCnt;
  logic [START_W-1:0] startCnt;
  logic [7:0]         shiftReg, byteCount;
  logic [2:0]         bitCnt;
  logic               bitOne;
  logic [7:0]         shiftNext;

  assign startExpired = (startCnt >= START_LIM);
  assign lowExpired   = (lowCnt >= BIT_LIM);
  assign highExpired  = (highCnt >= BIT_LIM);
  assign byteDone     = (bitCnt == 3'd7);
  assign atMax        = (byteCount == maxBytes);
  assign bitOne       = (highCnt > lowLen);
  assign shiftNext    = {shiftReg[6:0], bitOne};

  // phase timers, saturating at their limits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt   <= '0;
      lowLen   <= '0;
      highCnt  <= '0;
      startCnt <= '0;
    end else begin
      if (stb.loadLow)
        lowCnt <= BIT_W'(1);
      else if (stb.incLow && !lowExpired)
        lowCnt <= lowCnt + BIT_W'(1);

      if (stb.loadHigh) begin
        highCnt <= BIT_W'(1);
        lowLen  <= lowCnt;
      end else if (stb.incHigh && !highExpired)
        highCnt <= highCnt + BIT_W'(1);

      if (stb.clrStart)
        startCnt <= '0;
      else if (stb.incStart && !startExpired)
        startCnt <= startCnt + START_W'(1);
    end
  end

  // bit assembly, byte output and frame result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      bitCnt    <= '0;
      byteCount <= '0;
      rxByte    <= '0;
      rxValid   <= 1'b0;
      rxDone    <= 1'b0;
      rxStatus  <= '0;
    end else begin
      rxValid <= 1'b0;
      rxDone  <= 1'b0;
      if (stb.clrFrame) begin
        shiftReg  <= '0;
        bitCnt    <= '0;
        byteCount <= '0;
      end else if (stb.takeBit) begin
        shiftReg <= shiftNext;
        bitCnt   <= bitCnt + 3'd1;
        if (byteDone) begin
          rxByte    <= shiftNext;
          rxValid   <= 1'b1;
          byteCount <= byteCount + 8'd1;
        end
      end
      if (stb.endCount) begin
        rxStatus <= byteCount;
        rxDone   <= 1'b1;
      end else if (stb.endStuck) begin
        rxStatus <= STAT_STUCK;
        rxDone   <= 1'b1;
      end else if (stb.endOverflow) begin
        rxStatus <= STAT_OVERFLOW;
        rxDone   <= 1'b1;
      end
    end
  end

  // R5
  low_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= BIT_LIM);

  // R3
  high_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= BIT_LIM);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);

  // R2
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxDone));

  // R6
  valid_within_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (byteCount <= maxBytes));
endmodule

// File: rtl/pwRx.sv
module pwRx
  import pwRxPkg::*;
#(
  parameter int BIT_TIMEOUT   = 5000,
  parameter int START_TIMEOUT = 100000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic       rxEnable,
  input  logic [7:0] maxBytes,
  output logic [7:0] rxByte,
  output logic       rxValid,
  output logic       rxDone,
  output logic [7:0] rxStatus
);
  logic       lineS;
  rxStrobes_t stb;
  logic       startExpired, lowExpired, highExpired, byteDone, atMax;

  pwRxSync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rstN(rstN),
    .d   (lineIn),
    .q   (lineS)
  );

  pwRxControl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rxEnable    (rxEnable),
    .lineS       (lineS),
    .startExpired(startExpired),
    .lowExpired  (lowExpired),
    .highExpired (highExpired),
    .byteDone    (byteDone),
    .atMax       (atMax),
    .stb         (stb)
  );

  pwRxDatapath #(
    .BIT_TIMEOUT  (BIT_TIMEOUT),
    .START_TIMEOUT(START_TIMEOUT)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .maxBytes    (maxBytes),
    .startExpired(startExpired),
    .lowExpired  (lowExpired),
    .highExpired (highExpired),
    .byteDone    (byteDone),
    .atMax       (atMax),
    .rxByte      (rxByte),
    .rxValid     (rxValid),
    .rxDone      (rxDone),
    .rxStatus    (rxStatus)
  );
endmodule

// File: tb/test_pwRx.sv
module test_pwRx;
  localparam int T_BIT   = 40;
  localparam int T_START = 300;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineIn = 1'b1;
  logic       rxEnable = 1'b0;
  logic [7:0] maxBytes = 8'd4;
  logic [7:0] rxByte;
  logic       rxValid;
  logic       rxDone;
  logic [7:0] rxStatus;

  always #5 clk = ~clk;

  pwRx #(.BIT_TIMEOUT(T_BIT), .START_TIMEOUT(T_START)) i_pwRx (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .rxEnable(rxEnable),
    .maxBytes(maxBytes), .rxByte(rxByte), .rxValid(rxValid),
    .rxDone(rxDone), .rxStatus(rxStatus)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // monitor: sampled on falling edges
  logic [7:0] got [0:63];
  int gotN = 0;
  int doneN = 0;
  logic [7:0] lastStatus = 8'h00;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rxValid && gotN < 64) begin
      got[gotN] = rxByte;
      gotN = gotN + 1;
    end
    if (rxDone) begin
      lastStatus = rxStatus;
      doneN = doneN + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
        finishRun();
      end
    end
  end

  task automatic startRx(input logic [7:0] mx);
    @(negedge clk);
    maxBytes = mx;
    rxEnable = 1'b1;
    @(negedge clk);
    rxEnable = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic sendBit(input int lowN, input int highN, input bit pulseEn);
    lineIn = 1'b0;
    if (pulseEn) rxEnable = 1'b1;
    @(negedge clk);
    rxEnable = 1'b0;
    repeat (lowN - 1) @(negedge clk);
    lineIn = 1'b1;
    repeat (highN) @(negedge clk);
  endtask

  task automatic sendData(input logic [7:0] b, input int nBits);
    for (int i = 7; i > 7 - nBits; i--)
      sendBit(b[i] ? 8 : 24, b[i] ? 24 : 8, 1'b0);
  endtask

  task automatic waitDone(input int base);
    for (int i = 0; i < 600 && doneN == base; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // nBytes, byte0, byte1, extra bits, maxBytes, expected status
  localparam int NV = 5;
  localparam logic [7:0] VEC [NV][6] = '{
    '{8'd1, 8'hA5, 8'h00, 8'd0, 8'd4, 8'd1},
    '{8'd2, 8'h3C, 8'hF0, 8'd0, 8'd4, 8'd2},
    '{8'd2, 8'hFF, 8'h01, 8'd3, 8'd4, 8'd2},
    '{8'd2, 8'h81, 8'h7E, 8'd0, 8'd1, 8'hFE},
    '{8'd1, 8'h5A, 8'h00, 8'd0, 8'd0, 8'hFE}
  };

  initial begin
    int bBase, dBase, nExp;
    logic [7:0] data [2];
    repeat (4) @(negedge clk);
    // R9 reset state
    check(rxValid == 1'b0, "R9 valid", rxValid, 0);
    check(rxDone == 1'b0, "R9 done", rxDone, 0);
    check(rxStatus == 8'h00, "R9 status", rxStatus, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // table of frames: R1 R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      bBase = gotN;
      dBase = doneN;
      data[0] = VEC[v][1];
      data[1] = VEC[v][2];
      startRx(VEC[v][4]);
      for (int k = 0; k < int'(VEC[v][0]); k++) sendData(data[k], 8);
      if (VEC[v][3] != 0) sendData(8'h00, int'(VEC[v][3]));
      sendBit(8, 1, 1'b0);
      waitDone(dBase);
      nExp = (VEC[v][5] == 8'hFE) ? int'(VEC[v][4]) : int'(VEC[v][5]);
      check(doneN == dBase + 1, "R3 done pulse count", doneN - dBase, 1);
      check(lastStatus == VEC[v][5], "R3/R4/R6 status", lastStatus, VEC[v][5]);
      check(gotN - bBase == nExp, "R2/R4/R6 bytes emitted", gotN - bBase, nExp);
      for (int k = 0; k < nExp && k < 2; k++)
        check(got[bBase + k] == data[k], "R1/R2 byte value", got[bBase + k], data[k]);
    end

    // R1 equal phases decode as 0: first bit equal, rest ones
    bBase = gotN; dBase = doneN;
    startRx(8'd4);
    sendBit(16, 16, 1'b0);
    sendData(8'hFF, 7);
    sendBit(8, 1, 1'b0);
    waitDone(dBase);
    check(gotN - bBase == 1 && got[bBase] == 8'h7F, "R1 equal phases", got[bBase], 8'h7F);

    // R2 / R3 exact latencies
    bBase = gotN; dBase = doneN;
    startRx(8'd4);
    sendData(8'hC3, 8);
    lineIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(rxValid == 1'b0, "R2 valid not early", rxValid, 0);
    @(negedge clk);
    check(rxValid == 1'b1 && rxByte == 8'hC3, "R2 valid latency", rxByte, 8'hC3);
    repeat (5) @(negedge clk);
    lineIn = 1'b1;
    for (int i = 1; i <= T_BIT + 3; i++) begin
      @(negedge clk);
      if (i == T_BIT + 2) check(rxDone == 1'b0, "R3 done not early", rxDone, 0);
      if (i == T_BIT + 3) check(rxDone == 1'b1 && rxStatus == 8'd1, "R3 done latency", rxStatus, 1);
    end
    repeat (4) @(negedge clk);

    // R5 low of exactly the limit is valid
    dBase = doneN;
    startRx(8'd4);
    sendBit(T_BIT, 1, 1'b0);
    waitDone(dBase);
    check(lastStatus == 8'h00, "R5 low at limit accepted", lastStatus, 0);

    // R5 low one past the limit is stuck
    dBase = doneN;
    startRx(8'd4);
    sendBit(T_BIT + 1, 1, 1'b0);
    waitDone(dBase);
    check(lastStatus == 8'hFF, "R5 low past limit", lastStatus, 8'hFF);

    // R5 long stuck low after a byte
    dBase = doneN;
    startRx(8'd4);
    sendData(8'h11, 8);
    sendBit(100, 1, 1'b0);
    waitDone(dBase);
    check(lastStatus == 8'hFF, "R5 stuck low", lastStatus, 8'hFF);

    // R7 no activity
    bBase = gotN; dBase = doneN;
    startRx(8'd4);
    waitDone(dBase);
    check(doneN == dBase + 1 && lastStatus == 8'h00, "R7 start timeout status", lastStatus, 0);
    check(gotN == bBase, "R7 no bytes", gotN - bBase, 0);

    // R8 enable during frame ignored
    bBase = gotN; dBase = doneN;
    data[0] = 8'h96;
    startRx(8'd4);
    for (int i = 7; i >= 0; i--)
      sendBit(data[0][i] ? 8 : 24, data[0][i] ? 24 : 8, i == 3);
    sendBit(8, 1, 1'b0);
    waitDone(dBase);
    check(doneN == dBase + 1 && lastStatus == 8'd1, "R8 status", lastStatus, 1);
    check(gotN - bBase == 1 && got[bBase] == 8'h96, "R8 byte", got[bBase], 8'h96);

    finishRun();
  end
endmodule